// File: doc/BRIEF.md
# Outstanding-Aware Reply Queue Selector

This block chooses the reply queue index for every new I/O submission. It tracks, for each device, how many I/Os are still outstanding. Most submissions are sent to the low-latency queue that belongs to the submitting CPU. When a device has a deep backlog, its submissions are instead sent to a small pool of high-throughput queues, which sit at the bottom of the queue index space.

The high-throughput queues are visited round-robin, but the pointer advances only once per batch of submissions rather than once per I/O. A single batch counter and a single pointer serve all devices. A mode input and a configured pool size can switch the high-throughput path off, so that every submission takes the low-latency path.

The chosen index appears on a registered output one cycle after the submit strobe. Completion strobes lower the per-device count, so a device falls back to the low-latency path once its backlog drains.

Top module: `rqs_queue_selector`

## Requirements
- R1: `q_valid` is high exactly in the cycle after a cycle with `sub_valid` high, and low otherwise. While `q_valid` is low, `q_idx` keeps its last value.
- R2: A low-latency pick gives `q_idx = HT_MAX + sub_ll_off` (8 + offset by default). The result saturates at `TOTAL_Q-1` (127).
- R3: If the submitting device's outstanding count, taken before this submission is added, is 8 (`THRESH`) or less, the pick is low-latency.
- R4: If that count is above 8, the mode is on and the effective pool size is nonzero, the pick is the current high-throughput queue, an index in 0..pool-1.
- R5: The high-throughput pointer moves on by one after every 16 (`BATCH`) high-throughput picks, and wraps from pool-1 back to 0. The pointer is shared by all devices. Low-latency picks do not move it.
- R6: With `ht_en` low, or `ht_qcount` equal to 0, every pick is low-latency and the batch state does not move.
- R7: A `ht_qcount` value above `HT_MAX` (8) is treated as `HT_MAX`.
- R8: A submission adds one to the device's count and a completion subtracts one. The count never goes below 0 and never goes above its maximum value.
- R9: A submission and a completion for the same device in the same cycle leave that device's count unchanged.
- R10: Reset clears every count, the batch counter, the pointer, `q_valid` and `q_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submission strobe |
| sub_dev | input | DEV_W (4) | Device of the submission |
| sub_ll_off | input | QW (7) | Offset of the CPU's low-latency queue within the low-latency range |
| cmp_valid | input | 1 | Completion strobe |
| cmp_dev | input | DEV_W (4) | Device of the completion |
| ht_en | input | 1 | Enables the high-throughput path |
| ht_qcount | input | HCW (4) | Configured number of high-throughput queues |
| q_valid | output | 1 | Selection valid, one cycle after `sub_valid` |
| q_idx | output | QW (7) | Selected reply queue index |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the hold of `q_idx`;
- that the pointer stays inside the pool and does not move without a high-throughput pick;
- that the count does not go below zero and holds on a same-cycle submit and completion;
- that disabled mode never yields an index below 8.

Only the bench scenarios can show the full pattern of chosen indices:
- the exact threshold crossing at the ninth outstanding I/O;
- batch boundaries of 16 and the wrap at a reduced pool size;
- clamping of an oversized pool count;
- fallback behaviour while a backlog exists;
- the drain back to the low-latency path after completions.

// File: rtl/rqs_pkg.sv
package rqs_pkg;

   typedef enum logic {
      SRC_LOWLAT = 1'b0,
      SRC_HITPUT = 1'b1
   } pick_src_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/rqs_outstanding_table.sv
module rqs_outstanding_table #(
   parameter int unsigned NUM_DEV = 16,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned DEV_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sub_valid,
   input  logic [DEV_W-1:0] sub_dev,
   input  logic             cmp_valid,
   input  logic [DEV_W-1:0] cmp_dev,
   output logic [CNT_W-1:0] rd_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (NUM_DEV < 2)           $error("NUM_DEV must be at least 2");
   if ((1 << DEV_W) < NUM_DEV) $error("DEV_W too narrow for NUM_DEV");
   if (CNT_W < 5)             $error("CNT_W must exceed the threshold range");

   logic [CNT_W-1:0] cnt_all [NUM_DEV];

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      logic             hit_s;
      logic             hit_c;
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;

      assign hit_s = sub_valid && (sub_dev == DEV_W'(d));
      assign hit_c = cmp_valid && (cmp_dev == DEV_W'(d));

      always_comb begin
         cnt_d = cnt_q;
         if (hit_s && !hit_c && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
         end else if (hit_c && !hit_s && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_d;
      end

      assign cnt_all[d] = cnt_q;

      AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_s && hit_c) |=> $stable(cnt_q)); // R9
      AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_c && !hit_s && (cnt_q == '0)) |=> (cnt_q == '0)); // R8
      AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_s && !hit_c && (cnt_q == CNT_MAX)) |=> (cnt_q == CNT_MAX)); // R8
   end

   always_comb begin
      rd_cnt = '0;
      if (32'(sub_dev) < NUM_DEV) rd_cnt = cnt_all[sub_dev];
   end

endmodule

// File: rtl/rqs_rr_batcher.sv
module rqs_rr_batcher #(
   parameter int unsigned HT_MAX = 8,
   parameter int unsigned BATCH  = 16,
   parameter int unsigned HTW    = 3,
   parameter int unsigned HCW    = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic [HCW-1:0] eff_n,
   output logic [HTW-1:0] ptr
);

   localparam int unsigned BW = $clog2(BATCH);
   localparam logic [BW-1:0] LAST_IN_BATCH = BW'(BATCH - 1);

   if (HT_MAX < 2) $error("HT_MAX must be at least 2");
   if (BATCH < 2)  $error("BATCH must be at least 2");

   logic [HTW-1:0] ptr_q;
   logic [HTW-1:0] ptr_eff;
   logic [HTW-1:0] ptr_nxt;
   logic [BW-1:0]  bcnt_q;
   logic           batch_done;

   // Pointer beyond a shrunk pool restarts at queue 0
   assign ptr_eff = ({1'b0, ptr_q} < eff_n) ? ptr_q : '0;

   if ((1 << BW) == BATCH) begin : g_pow2_batch
      assign batch_done = &bcnt_q;
   end else begin : g_gen_batch
      assign batch_done = (bcnt_q == LAST_IN_BATCH);
   end

   always_comb begin
      if (({1'b0, ptr_eff} + 1'b1) >= eff_n) ptr_nxt = '0;
      else                                    ptr_nxt = ptr_eff + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         bcnt_q <= '0;
      end else if (adv) begin
         if (batch_done) begin
            bcnt_q <= '0;
            ptr_q  <= ptr_nxt;
         end else begin
            bcnt_q <= bcnt_q + 1'b1;
            ptr_q  <= ptr_eff;
         end
      end
   end

   assign ptr = ptr_eff;

   AST_PTR_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> ({1'b0, ptr} < eff_n)); // R4
   AST_BATCH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(ptr_q) && $stable(bcnt_q))); // R6
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && batch_done && (({1'b0, ptr_eff} + 1'b1) == eff_n)) |=> (ptr_q == '0)); // R5

endmodule

// File: rtl/rqs_ll_map.sv
module rqs_ll_map #(
   parameter int unsigned TOTAL_Q = 128,
   parameter int unsigned HT_MAX  = 8,
   parameter int unsigned QW      = 7
) (
   input  logic [QW-1:0] off,
   output logic [QW-1:0] idx
);

   localparam logic [QW:0] TOP_IDX = (QW+1)'(TOTAL_Q - 1);

   if (HT_MAX + 1 > TOTAL_Q) $error("pool does not fit into TOTAL_Q");

   logic [QW:0] sum;

   assign sum = {1'b0, off} + (QW+1)'(HT_MAX);
   assign idx = (sum > TOP_IDX) ? TOP_IDX[QW-1:0] : sum[QW-1:0];

endmodule

// File: rtl/rqs_queue_selector.sv
module rqs_queue_selector
   import rqs_pkg::*;
#(
   parameter int unsigned NUM_DEV = 16,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned TOTAL_Q = 128,
   parameter int unsigned HT_MAX  = 8,
   parameter int unsigned THRESH  = 8,
   parameter int unsigned BATCH   = 16,
   localparam int unsigned DEV_W  = clog2_min1(NUM_DEV),
   localparam int unsigned QW     = clog2_min1(TOTAL_Q),
   localparam int unsigned HTW    = clog2_min1(HT_MAX),
   localparam int unsigned HCW    = HTW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sub_valid,
   input  logic [DEV_W-1:0] sub_dev,
   input  logic [QW-1:0]    sub_ll_off,
   input  logic             cmp_valid,
   input  logic [DEV_W-1:0] cmp_dev,
   input  logic             ht_en,
   input  logic [HCW-1:0]   ht_qcount,
   output logic             q_valid,
   output logic [QW-1:0]    q_idx
);

   if (TOTAL_Q > 128)             $error("TOTAL_Q above 128");
   if (THRESH >= (1 << CNT_W) - 1) $error("THRESH must fit below the count ceiling");

   logic [CNT_W-1:0] dev_cnt;
   logic [HCW-1:0]   eff_n;
   logic             ht_on;
   pick_src_e        src;
   logic             adv;
   logic [HTW-1:0]   ht_ptr;
   logic [QW-1:0]    ll_idx;
   logic [QW-1:0]    pick_idx;

   rqs_outstanding_table #(
      .NUM_DEV (NUM_DEV),
      .CNT_W   (CNT_W),
      .DEV_W   (DEV_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_valid (sub_valid),
      .sub_dev   (sub_dev),
      .cmp_valid (cmp_valid),
      .cmp_dev   (cmp_dev),
      .rd_cnt    (dev_cnt)
   );

   assign eff_n = (ht_qcount > HCW'(HT_MAX)) ? HCW'(HT_MAX) : ht_qcount;
   assign ht_on = ht_en && (eff_n != '0);
   assign src   = (ht_on && (dev_cnt > CNT_W'(THRESH))) ? SRC_HITPUT : SRC_LOWLAT;
   assign adv   = sub_valid && (src == SRC_HITPUT);

   rqs_rr_batcher #(
      .HT_MAX (HT_MAX),
      .BATCH  (BATCH),
      .HTW    (HTW),
      .HCW    (HCW)
   ) u_batcher (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .eff_n (eff_n),
      .ptr   (ht_ptr)
   );

   rqs_ll_map #(
      .TOTAL_Q (TOTAL_Q),
      .HT_MAX  (HT_MAX),
      .QW      (QW)
   ) u_llmap (
      .off (sub_ll_off),
      .idx (ll_idx)
   );

   assign pick_idx = (src == SRC_HITPUT) ? QW'(ht_ptr) : ll_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_idx   <= '0;
      end else begin
         q_valid <= sub_valid;
         if (sub_valid) q_idx <= pick_idx;
      end
   end

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid |=> q_valid); // R1
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_valid |=> (!q_valid && $stable(q_idx))); // R1
   AST_FALLBACK_LL: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && !ht_on) |=> (q_idx >= QW'(HT_MAX))); // R6
   AST_HT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (q_idx < QW'(HT_MAX))); // R4

endmodule

// File: tb/rqs_queue_selector_bench.sv
module rqs_queue_selector_bench;

   typedef struct packed {
      logic [7:0] rep;
      logic       sub;
      logic [3:0] sdev;
      logic [6:0] off;
      logic       cmp;
      logic [3:0] cdev;
      logic       en;
      logic [3:0] hn;
      logic       ev;
      logic [6:0] eq;
      logic [3:0] req;
   } vec_t;

   // rep, sub, sdev, off, cmp, cdev, en, hn, ev, eq, req
   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{8'd9,  1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd13,  4'd3},  // R3 up to 8 outstanding
      '{8'd16, 1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd0,   4'd4},  // R4 batch on queue 0
      '{8'd16, 1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd1,   4'd5},  // R5 batch on queue 1
      '{8'd16, 1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd2,   4'd5},  // R5 batch on queue 2
      '{8'd1,  1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd0,   4'd5},  // R5 wrap to 0
      '{8'd1,  1'b1, 4'd5, 7'd0,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd8,   4'd2},  // R2 idle device
      '{8'd1,  1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b0, 4'd3, 1'b1, 7'd13,  4'd6},  // R6 mode off
      '{8'd1,  1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd0,   4'd6},  // R6 batch held
      '{8'd65, 1'b0, 4'd0, 7'd0,   1'b1, 4'd2, 1'b1, 4'd3, 1'b0, 7'd0,   4'd1},  // R1 no submit
      '{8'd1,  1'b1, 4'd2, 7'd5,   1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd13,  4'd8},  // R8 drained to 0
      '{8'd20, 1'b1, 4'd2, 7'd5,   1'b1, 4'd2, 1'b1, 4'd3, 1'b1, 7'd13,  4'd9},  // R9 same-cycle pair
      '{8'd1,  1'b1, 4'd2, 7'd119, 1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd127, 4'd2},  // R2 top index
      '{8'd1,  1'b1, 4'd2, 7'd125, 1'b0, 4'd0, 1'b1, 4'd3, 1'b1, 7'd127, 4'd2}   // R2 saturation
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sub_valid;
   logic [3:0] sub_dev;
   logic [6:0] sub_ll_off;
   logic       cmp_valid;
   logic [3:0] cmp_dev;
   logic       ht_en;
   logic [3:0] ht_qcount;
   logic       q_valid;
   logic [6:0] q_idx;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   rqs_queue_selector u_rqs_queue_selector (
      .clk        (clk),
      .rst_n      (rst_n),
      .sub_valid  (sub_valid),
      .sub_dev    (sub_dev),
      .sub_ll_off (sub_ll_off),
      .cmp_valid  (cmp_valid),
      .cmp_dev    (cmp_dev),
      .ht_en      (ht_en),
      .ht_qcount  (ht_qcount),
      .q_valid    (q_valid),
      .q_idx      (q_idx)
   );

   task automatic chk(input string req, input logic ev, input logic [6:0] eq);
      n_tests++;
      if (q_valid !== ev || (ev && q_idx !== eq)) begin
         n_fail++;
         $display("FAIL %s: q_valid=%0b q_idx=%0d expected q_valid=%0b q_idx=%0d",
                  req, q_valid, q_idx, ev, eq);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
   task automatic step(input logic s, input logic [3:0] sd, input logic [6:0] so,
                       input logic c, input logic [3:0] cd, input logic en, input logic [3:0] hn);
      sub_valid = s; sub_dev = sd; sub_ll_off = so;
      cmp_valid = c; cmp_dev = cd; ht_en = en; ht_qcount = hn;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      sub_valid = 1'b0; cmp_valid = 1'b0;
      sub_dev = '0; cmp_dev = '0; sub_ll_off = '0; ht_en = 1'b0; ht_qcount = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1500000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      chk("R10 reset state", 1'b0, 7'd0);
      if (q_idx !== 7'd0) begin
         n_tests++; n_fail++;
         $display("FAIL R10: q_idx=%0d expected 0", q_idx);
      end else n_tests++;
      step(1'b0, 4'd0, 7'd0, 1'b0, 4'd0, 1'b1, 4'd3);
      chk("R1 idle", 1'b0, 7'd0);

      for (int v = 0; v < NV; v++) begin
         for (int r = 0; r < int'(TBL[v].rep); r++) begin
            step(TBL[v].sub, TBL[v].sdev, TBL[v].off, TBL[v].cmp, TBL[v].cdev,
                 TBL[v].en, TBL[v].hn);
            chk($sformatf("R%0d vec %0d rep %0d", TBL[v].req, v, r), TBL[v].ev, TBL[v].eq);
         end
      end

      // R7: oversized pool count is treated as 8; R5 wrap after queue 7
      do_reset();
      for (int i = 0; i < 9; i++) begin
         step(1'b1, 4'd7, 7'd0, 1'b0, 4'd0, 1'b1, 4'd12);
         chk("R3 clamp warmup", 1'b1, 7'd8);
      end
      for (int k = 0; k < 8; k++) begin
         for (int i = 0; i < 16; i++) begin
            step(1'b1, 4'd7, 7'd0, 1'b0, 4'd0, 1'b1, 4'd12);
            chk("R7 clamped pool", 1'b1, 7'(k));
         end
      end
      step(1'b1, 4'd7, 7'd0, 1'b0, 4'd0, 1'b1, 4'd12);
      chk("R5 wrap after 7", 1'b1, 7'd0);

      // R6: pool size 0 means fallback even with a backlog
      step(1'b1, 4'd7, 7'd3, 1'b0, 4'd0, 1'b1, 4'd0);
      chk("R6 zero pool", 1'b1, 7'd11);

      // R10: reset clears the backlog of device 7
      do_reset();
      step(1'b1, 4'd7, 7'd0, 1'b0, 4'd0, 1'b1, 4'd8);
      chk("R10 count cleared", 1'b1, 7'd8);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule